// File: doc/BRIEF.md
# I2C Master Bit Timing Engine with Clock Stretching

This block turns single bit-level requests (START, STOP, write one bit, read one bit) into open-drain SCL and SDA waveforms for an I2C controller. A programmable divider sets the length of the SCL low and high phases in core-clock cycles. SDA changes only inside the SCL low phase, after a programmable hold delay measured from the falling SCL edge.

When the engine releases SCL, it does not start timing the high phase right away. It first waits until the SCL pin, passed through a two-flop synchronizer and an optional glitch filter of selectable depth, reads back high. A target device that holds SCL low therefore stretches the clock. The synchronizer and filter latency also lengthens every high phase, so the bus runs below the nominal divider rate.

A byte sequencer sits above this block. It issues one request, waits for a one-cycle completion pulse, and reads the sampled bit.

Top module: `sclgen_core`

## Requirements
- R1: After synchronous reset, scl_oe and sda_oe are 0 (both lines released), req_ready is 1 and done is 0.
- R2: A request is accepted on a clock edge where req_ready and req_valid are both 1. scl_oe is asserted on that edge and stays asserted for exactly cfg_div+1 cycles.
- R3: After SCL is released, the high phase is counted only once the filtered SCL input has been seen low and then high. The high phase lasts cfg_div+1 cycles. A write or read bit therefore completes (done pulse) 2*(cfg_div+1)+3+F cycles after the accepting edge, where F is cfg_filt. This assumes cfg_div ≥ 2+F.
- R4: While SCL is held low externally, the high phase does not advance. If the line rises T cycles after the accepting edge (T > cfg_div+1), done follows T+3+F+cfg_div+1 cycles after that edge.
- R5: cfg_filt=0 passes the synchronized SCL straight through. Values 1 to 3 accept a level change only after that many consecutive differing samples, so a one-cycle high pulse during a stretch is ignored when cfg_filt ≥ 2.
- R6: When the low-phase SDA target differs from the current sda_oe, sda_oe changes H cycles after the accepting edge. H is cfg_hold, raised to 1 when cfg_hold is 0 and capped at cfg_div when cfg_hold exceeds it.
- R7: Write bit (req_op=2): during the low phase sda_oe becomes the inverse of req_bit, and it holds that value through the SCL high phase.
- R8: Read bit (req_op=3): SDA is released. rd_bit takes the synchronized SDA value on the first counted cycle of the high phase, and later changes of SDA are not captured.
- R9: START (req_op=0): SDA is released in the low phase. After the high phase, sda_oe is asserted while SCL stays released and is held for cfg_div+1 cycles, for a total of 3*(cfg_div+1)+3+F cycles.
- R10: STOP (req_op=1): sda_oe is asserted in the low phase and released after the high phase while SCL stays released. It is held for cfg_div+1 cycles, with the same total as R9.
- R11: req_ready is 0 while a request runs. req_valid during that time is ignored. done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Phase length minus one, in core cycles |
| cfg_hold | input | HOLD_W | SDA hold delay after SCL falls |
| cfg_filt | input | FILT_W | SCL glitch filter depth (0 = bypass) |
| req_valid | input | 1 | Bit request valid |
| req_op | input | 2 | 0 START, 1 STOP, 2 write bit, 3 read bit |
| req_bit | input | 1 | Bit value for a write |
| req_ready | output | 1 | Engine idle, request can be taken |
| done | output | 1 | One-cycle pulse at request completion |
| rd_bit | output | 1 | Bit sampled by the last read |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the engine with its default widths: a 16-bit divider, an 8-bit hold field, a 2-bit filter field and two synchronizer stages. Because the divider and hold delay are runtime inputs, small divider values keep each bit short. This lets one run sweep every filter depth, both clamps of the hold delay, long stretches and filtered glitches. The open-drain lines are modelled as a wired-AND with an instant pull-up, so every completion time follows exactly from the divider, the filter depth and the moment the bench releases SCL.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bitop_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOW   = 3'd1,
    PH_WAITH = 3'd2,
    PH_HIGH  = 3'd3,
    PH_TAIL  = 3'd4
  } phase_e;

endpackage

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= {STAGES{RST_VAL}};
    end else begin
      sr[0] <= d;
      for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/sclgen_glitch_filter.sv
module sclgen_glitch_filter #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              din,
  output logic              dout
);

  logic              level;
  logic [MODE_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b1;
      run   <= '0;
    end else if (din == level) begin
      run <= '0;
    end else if (mode == '0) begin
      level <= din;
      run   <= '0;
    end else if (run == mode - 1'b1) begin
      level <= din;
      run   <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign dout = (mode == '0) ? din : level;

  AST_FILT_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (mode != '0 && din == level) |=> $stable(level)) else $error("filter moved on equal input"); // R5
  AST_FILT_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (mode != '0 && $stable(mode)) |-> (run < mode)) else $error("filter run exceeds depth"); // R5

endmodule

// File: rtl/sclgen_phase_timer.sv
module sclgen_phase_timer #(
  parameter int DIV_W  = 16,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic [HOLD_W-1:0] hold,
  output logic              at_hold,
  output logic              at_end
);

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] end_val;
  logic [CNT_W-1:0] div_ext;
  logic [CNT_W-1:0] hold_ext;
  logic [CNT_W-1:0] hold_eff;

  always_comb begin
    div_ext  = {1'b0, div};
    end_val  = div_ext + 1'b1;
    hold_ext = CNT_W'(hold);
    if (hold_ext == '0)          hold_eff = CNT_W'(1);
    else if (hold_ext > div_ext) hold_eff = (div_ext == '0) ? CNT_W'(1) : div_ext;
    else                         hold_eff = hold_ext;
  end

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (restart)         cnt <= CNT_W'(1);
    else if (run && !at_end)  cnt <= cnt + 1'b1;
  end

  assign at_end  = (cnt == end_val);
  assign at_hold = (cnt == hold_eff);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run && $stable(div)) |-> (cnt <= end_val)) else $error("phase count overran"); // R2

endmodule

// File: rtl/sclgen_core.sv
module sclgen_core
  import sclgen_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int HOLD_W      = 8,
  parameter int FILT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic [FILT_W-1:0] cfg_filt,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_bit,
  output logic              req_ready,
  output logic              done,
  output logic              rd_bit,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);

  phase_e ph;
  bitop_e op_q;
  logic   bit_q;
  logic   seen_low;
  logic   scl_s, scl_f, sda_s;
  logic   at_hold, at_end;
  logic   go_high, restart, run;

  sclgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s));

  sclgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

  sclgen_glitch_filter #(.MODE_W(FILT_W)) u_scl_filt (
    .clk(clk), .rst(rst), .mode(cfg_filt), .din(scl_s), .dout(scl_f));

  function automatic logic low_target(bitop_e o, logic b);
    case (o)
      OP_STOP:  return 1'b1;
      OP_WRITE: return !b;
      default:  return 1'b0;
    endcase
  endfunction

  assign req_ready = (ph == PH_IDLE);
  assign go_high   = (ph == PH_WAITH) && scl_f && seen_low;
  assign restart   = (req_ready && req_valid) || go_high ||
                     (ph == PH_HIGH && at_end && (op_q == OP_START || op_q == OP_STOP));
  assign run       = (ph == PH_LOW) || (ph == PH_HIGH) || (ph == PH_TAIL);

  sclgen_phase_timer #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .run(run),
    .div(cfg_div), .hold(cfg_hold), .at_hold(at_hold), .at_end(at_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      op_q     <= OP_START;
      bit_q    <= 1'b0;
      seen_low <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      done     <= 1'b0;
      rd_bit   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (req_valid) begin
            op_q     <= bitop_e'(req_op);
            bit_q    <= req_bit;
            seen_low <= 1'b0;
            scl_oe   <= 1'b1;
            ph       <= PH_LOW;
          end
        end
        PH_LOW: begin
          if (!scl_f) seen_low <= 1'b1;
          if (at_hold) sda_oe <= low_target(op_q, bit_q);
          if (at_end) begin
            scl_oe <= 1'b0;
            ph     <= PH_WAITH;
          end
        end
        PH_WAITH: begin
          if (!scl_f) seen_low <= 1'b1;
          if (go_high) begin
            ph <= PH_HIGH;
            if (op_q == OP_READ) rd_bit <= sda_s;
          end
        end
        PH_HIGH: begin
          if (at_end) begin
            if (op_q == OP_START) begin
              sda_oe <= 1'b1;
              ph     <= PH_TAIL;
            end else if (op_q == OP_STOP) begin
              sda_oe <= 1'b0;
              ph     <= PH_TAIL;
            end else begin
              ph   <= PH_IDLE;
              done <= 1'b1;
            end
          end
        end
        PH_TAIL: begin
          if (at_end) begin
            ph   <= PH_IDLE;
            done <= 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_LOW_DRIVES_SCL: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LOW) |-> scl_oe) else $error("SCL not driven in low phase"); // R2
  AST_NO_COUNT_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WAITH && !scl_f) |=> (ph == PH_WAITH)) else $error("high phase began on low SCL"); // R4
  AST_SDA_STILL_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_HIGH && $past(ph) == PH_HIGH) |-> $stable(sda_oe)) else $error("SDA moved while SCL high"); // R7
  AST_SCL_FREE_IN_TAIL: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_TAIL) |-> !scl_oe) else $error("SCL driven during start/stop tail"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready) else $error("done while busy"); // R11

endmodule

// File: tb/sclgen_core_tb_top.sv
module sclgen_core_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cfg_div;
  logic [7:0]  cfg_hold;
  logic [1:0]  cfg_filt;
  logic        req_valid;
  logic [1:0]  req_op;
  logic        req_bit;
  logic        req_ready, done, rd_bit;
  logic        scl_oe, sda_oe;
  logic        stretch_low;
  logic        slave_bit;
  logic        scl_line, sda_line;

  int checks = 0;
  int fails  = 0;
  int cyc_res, sda_res, ready_busy;

  always #4 clk = ~clk;

  assign scl_line = !scl_oe && !stretch_low;
  assign sda_line = !sda_oe && slave_bit;

  sclgen_core dut_i (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_hold(cfg_hold), .cfg_filt(cfg_filt),
    .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit),
    .req_ready(req_ready), .done(done), .rd_bit(rd_bit),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  // div, hold, filt, op, bit (slave bit for reads), stretch release cycle
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{5, 2,   0, 0, 0, 0},
    '{5, 3,   0, 2, 1, 0},
    '{7, 0,   1, 2, 0, 0},
    '{6, 200, 2, 2, 1, 0},
    '{9, 4,   3, 3, 0, 0},
    '{5, 2,   0, 2, 0, 30},
    '{8, 1,   1, 3, 1, 0},
    '{6, 3,   2, 1, 0, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hold_eff(input int d, input int h);
    if (h == 0) return 1;
    if (h > d) return (d == 0) ? 1 : d;
    return h;
  endfunction

  function automatic int exp_cycles(input int d, input int f, input int op, input int t);
    int base;
    base = (t > 0) ? (t + 3 + f + d + 1) : (2 * (d + 1) + 3 + f);
    if (op == 0 || op == 1) base += d + 1;
    return base;
  endfunction

  function automatic int low_tgt(input int op, input int b);
    if (op == 1) return 1;
    if (op == 2) return (b != 0) ? 0 : 1;
    return 0;
  endfunction

  task automatic run_op(input int op, input int b, input int d, input int stretch_t,
                        input int glitch_at, input int flip_at, input int keep_req);
    logic sda0;
    int   cyc;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_bit   = (b != 0);
    sda0      = sda_oe;
    if (stretch_t > 0) stretch_low = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (keep_req != 0) req_op = 2'd0;
    else req_valid = 1'b0;
    cyc = 0;
    sda_res = -1;
    ready_busy = -1;
    while (!done && cyc < 4000) begin
      if (sda_res < 0 && sda_oe != sda0 && cyc <= d + 1) sda_res = cyc;
      if (cyc == 1) ready_busy = int'(req_ready);
      if (keep_req != 0 && cyc == 4) req_valid = 1'b0;
      if (stretch_t > 0 && cyc == stretch_t) stretch_low = 1'b0;
      if (glitch_at > 0 && cyc == glitch_at) stretch_low = 1'b0;
      if (glitch_at > 0 && cyc == glitch_at + 1) stretch_low = 1'b1;
      if (flip_at > 0 && cyc == flip_at) slave_bit = ~slave_bit;
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    cyc_res = cyc;
    stretch_low = 1'b0;
  endtask

  task automatic set_cfg(input int d, input int h, input int f);
    @(negedge clk);
    cfg_div  = 16'(d);
    cfg_hold = 8'(h);
    cfg_filt = 2'(f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_div = 16'd5; cfg_hold = 8'd2; cfg_filt = 2'd0;
    req_valid = 1'b0; req_op = 2'd0; req_bit = 1'b0;
    stretch_low = 1'b0; slave_bit = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl_oe after reset", int'(scl_oe), 0);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);
    chk("R1 done after reset", int'(done), 0);
    repeat (6) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int d, h, f, op, b, t, sexp;
      d = VEC[i][0]; h = VEC[i][1]; f = VEC[i][2];
      op = VEC[i][3]; b = VEC[i][4]; t = VEC[i][5];
      set_cfg(d, h, f);
      if (op == 3) slave_bit = (b != 0);
      sexp = (low_tgt(op, b) != int'(sda_oe)) ? hold_eff(d, h) : -1;
      run_op(op, b, d, t, 0, 0, 0);
      slave_bit = 1'b1;
      if (t > 0) chk("R4 stretched completion cycles", cyc_res, exp_cycles(d, f, op, t));
      else if (op >= 2) chk("R3 bit completion cycles", cyc_res, exp_cycles(d, f, op, t));
      else chk("R9 R10 start/stop completion cycles", cyc_res, exp_cycles(d, f, op, t));
      chk("R6 sda change cycle in low phase", sda_res, sexp);
      case (op)
        0: chk("R9 sda_oe held after START", int'(sda_oe), 1);
        1: chk("R10 sda_oe released after STOP", int'(sda_oe), 0);
        2: chk("R7 sda_oe after write bit", int'(sda_oe), (b != 0) ? 0 : 1);
        default: chk("R8 read bit value", int'(rd_bit), b);
      endcase
      chk("R2 scl released after op", int'(scl_oe), 0);
      repeat (3) @(negedge clk);
    end

    // R5: one-cycle high glitch during a stretch is filtered at depth 2
    set_cfg(5, 2, 2);
    run_op(2, 1, 5, 20, 10, 0, 0);
    chk("R5 glitch rejected, filter depth 2", cyc_res, 20 + 3 + 2 + 6);
    repeat (3) @(negedge clk);
    // R5: same glitch passes in bypass and starts the high phase
    set_cfg(5, 2, 0);
    run_op(2, 1, 5, 20, 10, 0, 0);
    chk("R5 glitch accepted in bypass", cyc_res, 10 + 3 + 6);
    repeat (3) @(negedge clk);

    // R8: SDA flipped late in the high phase is not captured
    set_cfg(20, 3, 0);
    slave_bit = 1'b1;
    run_op(3, 0, 20, 0, 0, 42, 0);
    chk("R8 sample taken at start of high phase", int'(rd_bit), 1);
    chk("R3 read completion cycles", cyc_res, 2 * 21 + 3);
    slave_bit = 1'b1;
    repeat (3) @(negedge clk);

    // R11: request held during a busy op is ignored
    set_cfg(6, 2, 1);
    run_op(2, 0, 6, 0, 0, 0, 1);
    chk("R11 ready low while busy", ready_busy, 0);
    chk("R11 completion unaffected by held request", cyc_res, 2 * 7 + 4);
    begin
      int extra = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done || scl_oe) extra++;
      end
      chk("R11 no second op from ignored request", extra, 0);
    end
    chk("R11 ready after done", int'(req_ready), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule